// File: doc/BRIEF.md
# Paired Burst Acquisition Scheduler

This block decides when a capacitive-key measurement engine runs its acquisition bursts. The eight keys are covered by two bursts. Group A covers keys 0, 1, 4 and 5. Group B covers keys 2, 3, 6 and 7. The scheduler always issues the two bursts as a pair, A first and then B. For each burst it sends a one-cycle start pulse with a group select, then waits for the engine's completion pulse before it moves on.

A 2-bit pin mode sets the pacing of the pairs. In sync mode, the scheduler launches one pair per rising edge on the sync/low-power pin. In the three low-power modes, it sleeps for a fixed number of millisecond ticks between pairs. A touch reported at the end of a pair moves the block to full speed, where pairs run back to back. A later rising edge on the same pin returns it to low-power pacing.

After reset, the scheduler runs pairs continuously for a calibration window, whatever the pin mode. When the window ends, it raises a sticky calibration-complete flag.

Top module: `burst_sched`

## Requirements
- R1: `burst_grp_o` encodes the group: 0 is group A (keys 0, 1, 4, 5) and 1 is group B (keys 2, 3, 6, 7). Bursts strictly alternate A, B, A, B. The first burst after reset is A. The B burst of a pair starts in the cycle after the A burst's `burst_done_i` is seen.
- R2: `burst_start_o` is a pulse that lasts one cycle. No new burst starts while the current one has not reported `burst_done_i`.
- R3: `pin_mode_i` is {bit1, bit0}. 2'b00 selects sync mode. 2'b10 selects low-power with period LP_FAST_MS. 2'b01 selects low-power with period LP_MID_MS. 2'b11 selects low-power with period LP_SLOW_MS. In sync mode, `sleep_o` is low from the cycle after the mode is applied.
- R4: In sync mode, after calibration, each rising edge on `sync_pin_i` launches exactly one A-B pair, seen at the pin through a two-stage synchronizer. With no edge, no burst starts.
- R5: In sync mode, an edge that arrives while a pair runs is held and served as soon as that pair ends. Any number of such edges during one pair yields only one extra pair.
- R6: In a low-power mode, `sleep_o` is high between pairs for exactly the period of the selected mode, counted in cycles with `ms_tick_i` high. Cycles without a tick do not advance the count. No burst starts while `sleep_o` is high.
- R7: In a low-power mode, `any_detect_i` high when B completes switches the block to full speed. At full speed, pairs run back to back with no sleep, even after `any_detect_i` falls, until a rising edge on `sync_pin_i`. After that edge, the next pair end enters sleep unless a touch is still reported.
- R8: From reset, pairs run back to back for CAL_MS ticks whatever the mode. `cal_done_o` then rises and stays high. `sleep_o` is never high while `cal_done_o` is low.
- R9: During reset, `burst_start_o`, `sleep_o` and `cal_done_o` are all low.
- R10: At full speed, and during calibration, the next A burst starts in the cycle after B's `burst_done_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_pin_i | input | 1 | Sync / low-power pin (asynchronous) |
| pin_mode_i | input | 2 | Pin mode code |
| ms_tick_i | input | 1 | One-cycle millisecond tick |
| burst_done_i | input | 1 | Engine reports the current burst finished |
| any_detect_i | input | 1 | Any key currently in detect |
| burst_start_o | output | 1 | Start pulse for one burst |
| burst_grp_o | output | 1 | Group of the burst started (0 = A, 1 = B) |
| sleep_o | output | 1 | Sleeping between pairs |
| cal_done_o | output | 1 | Power-up calibration window elapsed |

## Verification
The bench measures the sleep length for each low-power code. A swapped code decode or an off-by-one counter shows up as a wrong count. It sends two sync edges into a running pair and expects exactly two pairs in total. A scheduler that drops held edges yields only one pair, and one that queues every edge yields three. It also holds the tick low during sleep to catch a counter that runs on the clock. Finally, it checks that full speed outlives the touch and ends only on a pin edge, which exposes a design that keys full speed directly off `any_detect_i`.

// File: rtl/bsch_pkg.sv
package bsch_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SLEEP,
        ST_RUN_A,
        ST_RUN_B
    } sched_st_e;

    localparam logic [1:0] MODE_SYNC    = 2'b00;
    localparam logic [1:0] MODE_LP_FAST = 2'b10;
    localparam logic [1:0] MODE_LP_MID  = 2'b01;
    localparam logic [1:0] MODE_LP_SLOW = 2'b11;

    localparam logic GRP_A = 1'b0;
    localparam logic GRP_B = 1'b1;
endpackage

// File: rtl/bsch_pin_sync.sv
module bsch_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o
);
    // sh[0] is the first stage; sh[STAGES] holds the previous synchronized value
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], pin_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/bsch_cal_timer.sv
module bsch_cal_timer #(
    parameter int CAL_MS = 350
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    output logic done_o
);
    localparam int CW = $clog2(CAL_MS + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          done;
    } cal_t;

    cal_t cal_d, cal_q;

    always_comb begin
        cal_d = cal_q;
        if (!cal_q.done && tick_i) begin
            cal_d.cnt = cal_q.cnt + 1'b1;
            if (cal_q.cnt == CW'(CAL_MS - 1)) cal_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cal_q <= '0;
        else        cal_q <= cal_d;
    end

    assign done_o = cal_q.done;
endmodule

// File: rtl/burst_sched.sv
module burst_sched
    import bsch_pkg::*;
#(
    parameter int CAL_MS      = 350,
    parameter int LP_FAST_MS  = 110,
    parameter int LP_MID_MS   = 200,
    parameter int LP_SLOW_MS  = 360,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sync_pin_i,
    input  logic [1:0] pin_mode_i,
    input  logic       ms_tick_i,
    input  logic       burst_done_i,
    input  logic       any_detect_i,
    output logic       burst_start_o,
    output logic       burst_grp_o,
    output logic       sleep_o,
    output logic       cal_done_o
);
    localparam int MAX_A  = (LP_FAST_MS > LP_MID_MS) ? LP_FAST_MS : LP_MID_MS;
    localparam int MAX_P  = (MAX_A > LP_SLOW_MS) ? MAX_A : LP_SLOW_MS;
    localparam int CNT_W  = $clog2(MAX_P + 1);

    typedef struct packed {
        sched_st_e      st;
        logic           start;
        logic           grp;
        logic           fast;
        logic           pend;
        logic [CNT_W-1:0] slp_cnt;
    } sched_t;

    sched_t s_d, s_q;
    logic   pin_rise;
    logic   cal_done;
    logic   [CNT_W-1:0] period;
    logic   is_sync;
    logic   fast_live;
    logic   do_launch;
    logic   done_ok;

    bsch_pin_sync #(.STAGES(SYNC_STAGES)) i_pin_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (sync_pin_i),
        .rise_o (pin_rise)
    );

    bsch_cal_timer #(.CAL_MS(CAL_MS)) i_cal_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (ms_tick_i),
        .done_o (cal_done)
    );

    always_comb begin
        unique case (pin_mode_i)
            MODE_LP_FAST: period = CNT_W'(LP_FAST_MS);
            MODE_LP_MID:  period = CNT_W'(LP_MID_MS);
            MODE_LP_SLOW: period = CNT_W'(LP_SLOW_MS);
            default:      period = CNT_W'(LP_SLOW_MS);
        endcase
    end

    always_comb begin
        s_d       = s_q;
        s_d.start = 1'b0;
        do_launch = 1'b0;
        is_sync   = (pin_mode_i == MODE_SYNC);
        // a completion in the same cycle as our own start pulse is ignored
        done_ok   = burst_done_i && !s_q.start;
        // full speed ends on a pin edge, and never applies in sync mode
        fast_live = s_q.fast && !is_sync && !pin_rise;
        s_d.fast  = fast_live;

        if (!is_sync) begin
            s_d.pend = 1'b0;
        end else if (pin_rise && (s_q.st == ST_RUN_A || s_q.st == ST_RUN_B)) begin
            s_d.pend = 1'b1;
        end

        case (s_q.st)
            ST_IDLE: begin
                if (!cal_done || fast_live) begin
                    do_launch = 1'b1;
                end else if (is_sync) begin
                    if (pin_rise || s_q.pend) do_launch = 1'b1;
                end else begin
                    s_d.st      = ST_SLEEP;
                    s_d.slp_cnt = '0;
                end
            end
            ST_SLEEP: begin
                if (is_sync) begin
                    s_d.st = ST_IDLE;
                end else if (ms_tick_i) begin
                    if (s_q.slp_cnt >= period - 1'b1) do_launch = 1'b1;
                    else s_d.slp_cnt = s_q.slp_cnt + 1'b1;
                end
            end
            ST_RUN_A: begin
                if (done_ok) begin
                    s_d.st    = ST_RUN_B;
                    s_d.start = 1'b1;
                    s_d.grp   = GRP_B;
                end
            end
            ST_RUN_B: begin
                if (done_ok) begin
                    if (!cal_done) begin
                        do_launch = 1'b1;
                    end else if (is_sync) begin
                        if (s_q.pend || pin_rise) do_launch = 1'b1;
                        else s_d.st = ST_IDLE;
                    end else if (fast_live || any_detect_i) begin
                        s_d.fast  = 1'b1;
                        do_launch = 1'b1;
                    end else begin
                        s_d.st      = ST_SLEEP;
                        s_d.slp_cnt = '0;
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase

        if (do_launch) begin
            s_d.st    = ST_RUN_A;
            s_d.start = 1'b1;
            s_d.grp   = GRP_A;
            s_d.pend  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.st  <= ST_IDLE;
            s_q.grp <= GRP_A;
        end else begin
            s_q <= s_d;
        end
    end

    assign burst_start_o = s_q.start;
    assign burst_grp_o   = s_q.grp;
    assign sleep_o       = (s_q.st == ST_SLEEP);
    assign cal_done_o    = cal_done;
endmodule

// File: rtl/burst_sched_chk.sv
module burst_sched_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] pin_mode_i,
    input logic       burst_start_o,
    input logic       burst_grp_o,
    input logic       sleep_o,
    input logic       cal_done_o
);
    logic last_grp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             last_grp_q <= 1'b1;
        else if (burst_start_o) last_grp_q <= burst_grp_o;
    end

    assert_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        burst_start_o |=> !burst_start_o);

    assert_alternate_R1: assert property (@(posedge clk) disable iff (!rst_n)
        burst_start_o |-> (burst_grp_o != last_grp_q));

    assert_cal_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(cal_done_o));

    assert_no_sleep_in_cal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_o |-> cal_done_o);

    assert_sync_awake_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_mode_i == 2'b00) |=> !sleep_o);

    assert_sleep_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_o |-> !burst_start_o);
endmodule

bind burst_sched burst_sched_chk i_burst_sched_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pin_mode_i    (pin_mode_i),
    .burst_start_o (burst_start_o),
    .burst_grp_o   (burst_grp_o),
    .sleep_o       (sleep_o),
    .cal_done_o    (cal_done_o)
);

// File: tb/test_burst_sched.sv
module test_burst_sched;
    localparam int CAL   = 20;
    localparam int PFAST = 5;
    localparam int PMID  = 8;
    localparam int PSLOW = 12;
    localparam int DLAT  = 6;

    // {mode[1:0], expected sleep length[3:0]}
    localparam logic [5:0] LP_VEC [3] = '{
        {2'b10, 4'd5},
        {2'b01, 4'd8},
        {2'b11, 4'd12}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_pin = 1'b0;
    logic [1:0] mode = 2'b01;
    logic       tick = 1'b1;
    logic       done = 1'b0;
    logic       detect = 1'b0;
    logic       start, grp, sleep, cal_done;

    int  n_tests = 0;
    int  n_fail  = 0;
    int  n_starts = 0;
    logic exp_grp = 1'b0;
    logic chk_b2b = 1'b1;

    always #2 clk = ~clk;

    burst_sched #(
        .CAL_MS(CAL), .LP_FAST_MS(PFAST), .LP_MID_MS(PMID), .LP_SLOW_MS(PSLOW)
    ) i_burst_sched (
        .clk(clk), .rst_n(rst_n), .sync_pin_i(sync_pin), .pin_mode_i(mode),
        .ms_tick_i(tick), .burst_done_i(done), .any_detect_i(detect),
        .burst_start_o(start), .burst_grp_o(grp), .sleep_o(sleep),
        .cal_done_o(cal_done)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse_pin(input int hi, input int lo);
        sync_pin = 1'b1;
        repeat (hi) @(negedge clk);
        sync_pin = 1'b0;
        repeat (lo) @(negedge clk);
    endtask

    // measurement engine model and order monitor
    initial begin
        forever begin
            @(negedge clk);
            while (rst_n && start) begin
                logic g;
                g = grp;
                n_starts++;
                check("R1 group order", int'(g), int'(exp_grp));
                exp_grp = ~g;
                repeat (DLAT) @(negedge clk);
                done = 1'b1;
                @(negedge clk);
                done = 1'b0;
                if (g == 1'b0) check("R1 B follows A done", int'(start), 1);
                else if (chk_b2b) check("R10 A follows B done", int'(start), 1);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int base, len, seen;
        // R9 reset state
        repeat (3) @(negedge clk);
        check("R9 start in reset", int'(start), 0);
        check("R9 sleep in reset", int'(sleep), 0);
        check("R9 cal_done in reset", int'(cal_done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 first burst is A at once", int'(start && grp == 1'b0), 1);
        repeat (8) @(negedge clk);
        check("R8 cal not done early", int'(cal_done), 0);
        seen = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (sleep && !cal_done) seen = 1;
        end
        check("R8 no sleep during calibration", seen, 0);
        repeat (6) @(negedge clk);
        check("R8 cal done after window", int'(cal_done), 1);
        chk_b2b = 1'b0;

        // R6 / R3 sleep length per low-power code
        for (int v = 0; v < 3; v++) begin
            mode = LP_VEC[v][5:4];
            len = 0;
            for (int k = 0; k < 200 && sleep; k++) @(negedge clk);
            for (int k = 0; k < 200 && !sleep; k++) @(negedge clk);
            while (sleep && len < 100) begin
                len++;
                @(negedge clk);
            end
            check("R6 R3 sleep length for mode", len, int'(LP_VEC[v][3:0]));
        end
        check("R8 cal_done stays high", int'(cal_done), 1);

        // R4 sync: silence without edges, one pair per edge
        mode = 2'b00;
        repeat (30) @(negedge clk);
        check("R3 awake in sync mode", int'(sleep), 0);
        base = n_starts;
        repeat (40) @(negedge clk);
        check("R4 no bursts without edge", n_starts - base, 0);
        base = n_starts;
        pulse_pin(3, 40);
        check("R4 one pair per edge", n_starts - base, 2);

        // R5 edges during a pair held and collapsed
        base = n_starts;
        sync_pin = 1'b1;
        for (int k = 0; k < 20 && n_starts == base; k++) @(negedge clk);
        sync_pin = 1'b0;
        @(negedge clk);
        pulse_pin(2, 2);
        pulse_pin(2, 2);
        repeat (60) @(negedge clk);
        check("R5 held edges give one extra pair", n_starts - base, 4);

        // R6 tick gating
        mode = 2'b11;
        tick = 1'b0;
        repeat (5) @(negedge clk);
        check("R6 enters sleep in low-power mode", int'(sleep), 1);
        base = n_starts;
        repeat (50) @(negedge clk);
        check("R6 sleep holds without ticks", int'(sleep), 1);
        check("R6 no burst without ticks", n_starts - base, 0);
        tick = 1'b1;

        // R7 full speed on touch, exit on pin edge
        mode = 2'b10;
        for (int k = 0; k < 200 && sleep; k++) @(negedge clk);
        detect = 1'b1;
        chk_b2b = 1'b1;
        base = n_starts;
        seen = 0;
        for (int k = 0; k < 80; k++) begin
            @(negedge clk);
            if (sleep) seen = 1;
        end
        check("R7 no sleep at full speed", seen, 0);
        check("R7 pairs keep running", int'(n_starts - base >= 8), 1);
        detect = 1'b0;
        seen = 0;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            if (sleep) seen = 1;
        end
        check("R7 full speed outlives touch", seen, 0);
        chk_b2b = 1'b0;
        pulse_pin(3, 0);
        seen = 0;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            if (sleep) seen = 1;
        end
        check("R7 pin edge returns to sleep", seen, 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule